// File: doc/BRIEF.md
# Spike Bin Merging Thresholder

This block sits at the front of a neural decoder. Each narrow time bin gives it one bit per neuron, and each bit says whether that neuron fired in the bin. A narrow bin is short enough to hold one spike at most. The block gathers a fixed number of consecutive valid narrow bins into one merged bin. For each neuron it counts the spikes in that window and compares the count with a threshold, which gives one bit per neuron per merged bin. No firing rate is ever stored or output.

The merged bits go into a shift history that holds the most recent merged bins. A downstream linear classifier reads all of them in parallel. A one-cycle pulse marks each cycle in which a new merged bin has entered the history. A flag shows when the history holds a full set of real merged bins. The block has its own clock and its own active-low reset. The reset asserts asynchronously and is released through a two-stage synchronizer.

Top module: `spike_bin_merger`

## Requirements
- R1: After reset, every history bit is 0, `win_done` is 0 and `hist_full` is 0.
- R2: Every `WIN_LEN` (default 9) accepted narrow bins close one merged bin. `win_done` is high for exactly the one cycle after the clock edge that accepts the last bin of the window.
- R3: A neuron's merged bit is 1 when its spike count over the window is at least `THRESH` (default 1), and 0 otherwise. With the default, any single spike in the window gives a 1.
- R4: A cycle with `spike_valid` low is not counted as a bin. Its `spike_bits` have no effect on any merged bit.
- R5: Slot 0 (bits `[N-1:0]`) of `merged_hist` holds the newest merged bin. Slot k (bits `[k*N +: N]`) holds the merged bin from k windows earlier. With the default depth of 20, the oldest bin is dropped when a new one enters. The history changes only when a window closes.
- R6: Spike counts clear at each window boundary, so spikes in one window never affect the next.
- R7: `hist_full` rises when the `HIST_DEPTH`-th merged bin since reset enters the history, and it stays high until reset.
- R8: The `NUM_NEURONS` (default 32) neurons are processed in parallel and independently. A spike on one neuron sets only that neuron's bit.
- R9: Driving `rst_n` low clears the history, `win_done` and `hist_full` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the merging unit |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously inside the block |
| spike_valid | input | 1 | High when `spike_bits` carries one narrow bin |
| spike_bits | input | NUM_NEURONS | Spike occurrence bit per neuron for the current narrow bin |
| merged_hist | output | HIST_DEPTH*NUM_NEURONS | Merged-bin history; slot k at bits `[k*NUM_NEURONS +: NUM_NEURONS]`, slot 0 newest |
| win_done | output | 1 | One-cycle pulse when a new merged bin has entered the history |
| hist_full | output | 1 | High once the history holds HIST_DEPTH merged bins |

## Verification
Sparse random spike trains, with about one spike in sixteen bits, give windows in which some neurons end at 0 and others at 1. This tests the threshold compare across all neurons at once and runs the history past its depth. Several directed windows separate the corner cases. A single spike on one neuron in the first bin shows that neurons are independent and that one spike meets the default threshold. Invalid cycles carrying all ones show that they are not counted. All ones in the last bin followed by an empty window shows that the counters clear at the boundary. An asynchronous reset in the middle of the run shows that the clear does not wait for a clock edge.

// File: rtl/spkm_pkg.sv
package spkm_pkg;
  localparam int unsigned DEF_NEURONS = 32;
  localparam int unsigned DEF_WIN_LEN = 9;
  localparam int unsigned DEF_THRESH  = 1;
  localparam int unsigned DEF_DEPTH   = 20;

  // width needed to hold values 0..v, at least one bit
  function automatic int unsigned spkm_cw(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction
endpackage

// File: rtl/spkm_rst_sync.sv
module spkm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/spkm_bin_timer.sv
module spkm_bin_timer #(
  parameter int unsigned WIN_LEN = spkm_pkg::DEF_WIN_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bin_valid,
  output logic win_close
);
  localparam int unsigned IW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [IW-1:0] LAST = IW'(WIN_LEN - 1);

  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_d;
  logic          idx_en;

  assign win_close = bin_valid && (idx_q == LAST);
  assign idx_en    = bin_valid;

  always_comb begin
    idx_d = idx_q;
    if (idx_en) begin
      if (idx_q == LAST) idx_d = '0;
      else               idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST);

  // R4
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bin_valid |=> $stable(idx_q));
endmodule

// File: rtl/spkm_neuron_acc.sv
module spkm_neuron_acc #(
  parameter int unsigned THRESH = spkm_pkg::DEF_THRESH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bin_valid,
  input  logic spike,
  input  logic win_close,
  output logic merged_bit
);
  localparam int unsigned CW = spkm_pkg::spkm_cw(THRESH);
  localparam logic [CW:0] TH = (CW+1)'(THRESH);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW:0]   sum;
  logic [CW:0]   sat;

  always_comb begin
    sum = {1'b0, cnt_q} + {{CW{1'b0}}, spike};
    sat = (sum >= TH) ? TH : sum;
  end

  assign merged_bit = (sat >= TH);

  always_comb begin
    cnt_d = cnt_q;
    if (bin_valid) begin
      if (win_close) cnt_d = '0;
      else           cnt_d = sat[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (bin_valid) cnt_q <= cnt_d;
  end

  // R3
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt_q} <= TH);

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bin_valid |=> $stable(cnt_q));

  // R6
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_valid && win_close) |=> (cnt_q == '0));
endmodule

// File: rtl/spkm_hist_shift.sv
module spkm_hist_shift #(
  parameter int unsigned N     = spkm_pkg::DEF_NEURONS,
  parameter int unsigned DEPTH = spkm_pkg::DEF_DEPTH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic [N-1:0]       din,
  output logic [DEPTH*N-1:0] hist,
  output logic               full
);
  localparam int unsigned FW = spkm_pkg::spkm_cw(DEPTH);
  localparam logic [FW-1:0] FULL_CNT = FW'(DEPTH);

  logic [DEPTH*N-1:0] hist_q;
  logic [DEPTH*N-1:0] hist_d;
  logic [FW-1:0]      fill_q;
  logic [FW-1:0]      fill_d;
  logic               fill_en;

  generate
    if (DEPTH == 1) begin : g_single
      always_comb hist_d = din;
    end else begin : g_chain
      always_comb hist_d = {hist_q[(DEPTH-1)*N-1:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end

  assign fill_en = shift_en && (fill_q != FULL_CNT);

  always_comb begin
    fill_d = fill_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fill_q <= '0;
    else if (fill_en) fill_q <= fill_d;
  end

  assign hist = hist_q;
  assign full = (fill_q == FULL_CNT);

  // R5
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q));

  // R5
  hist_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (hist_q[N-1:0] == $past(din)));

  // R7
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full);

  generate
    if (DEPTH > 1) begin : g_age_chk
      // R5
      hist_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (hist_q[2*N-1:N] == $past(hist_q[N-1:0])));
    end
  endgenerate
endmodule

// File: rtl/spike_bin_merger.sv
module spike_bin_merger #(
  parameter int unsigned NUM_NEURONS = spkm_pkg::DEF_NEURONS,
  parameter int unsigned WIN_LEN     = spkm_pkg::DEF_WIN_LEN,
  parameter int unsigned THRESH      = spkm_pkg::DEF_THRESH,
  parameter int unsigned HIST_DEPTH  = spkm_pkg::DEF_DEPTH
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          spike_valid,
  input  logic [NUM_NEURONS-1:0]        spike_bits,
  output logic [HIST_DEPTH*NUM_NEURONS-1:0] merged_hist,
  output logic                          win_done,
  output logic                          hist_full
);
  logic                   srst_n;
  logic                   win_close;
  logic                   shift_en;
  logic [NUM_NEURONS-1:0] merged_vec;
  logic                   done_q;
  logic                   done_d;

  spkm_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  spkm_bin_timer #(.WIN_LEN(WIN_LEN)) u_timer (
    .clk       (clk),
    .rst_n     (srst_n),
    .bin_valid (spike_valid),
    .win_close (win_close)
  );

  generate
    for (genvar n = 0; n < NUM_NEURONS; n++) begin : g_neuron
      spkm_neuron_acc #(.THRESH(THRESH)) u_acc (
        .clk        (clk),
        .rst_n      (srst_n),
        .bin_valid  (spike_valid),
        .spike      (spike_bits[n]),
        .win_close  (win_close),
        .merged_bit (merged_vec[n])
      );
    end
  endgenerate

  assign shift_en = win_close;

  spkm_hist_shift #(.N(NUM_NEURONS), .DEPTH(HIST_DEPTH)) u_hist (
    .clk      (clk),
    .rst_n    (srst_n),
    .shift_en (shift_en),
    .din      (merged_vec),
    .hist     (merged_hist),
    .full     (hist_full)
  );

  always_comb begin
    done_d = shift_en;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) done_q <= 1'b0;
    else         done_q <= done_d;
  end

  assign win_done = done_q;

  generate
    if (WIN_LEN > 1) begin : g_pulse_chk
      // R2
      done_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
        win_done |=> !win_done);
    end
  endgenerate

  // R2
  done_follows_chk: assert property (@(posedge clk) disable iff (!srst_n)
    win_done |-> $past(spike_valid));
endmodule

// File: tb/tb_spike_bin_merger.sv
module tb_spike_bin_merger;
  localparam int NEU   = 32;
  localparam int WIN   = 9;
  localparam int TH    = 1;
  localparam int DEPTH = 20;

  logic                   clk;
  logic                   rst_n;
  logic                   spike_valid;
  logic [NEU-1:0]         spike_bits;
  logic [DEPTH*NEU-1:0]   merged_hist;
  logic                   win_done;
  logic                   hist_full;

  int checks;
  int errors;
  bit finished;

  int             m_cnt [NEU];
  int             m_idx;
  logic [NEU-1:0] m_hist [DEPTH];
  int             m_filled;
  bit             m_done;

  spike_bin_merger #(
    .NUM_NEURONS(NEU), .WIN_LEN(WIN), .THRESH(TH), .HIST_DEPTH(DEPTH)
  ) dut (
    .clk(clk), .rst_n(rst_n), .spike_valid(spike_valid),
    .spike_bits(spike_bits), .merged_hist(merged_hist),
    .win_done(win_done), .hist_full(hist_full)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [NEU-1:0] slot(input int k);
    return merged_hist[k*NEU +: NEU];
  endfunction

  task automatic model_clear();
    for (int n = 0; n < NEU; n++) m_cnt[n] = 0;
    for (int k = 0; k < DEPTH; k++) m_hist[k] = '0;
    m_idx = 0;
    m_filled = 0;
    m_done = 0;
  endtask

  task automatic do_reset();
    spike_valid = 1'b0;
    spike_bits  = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    model_clear();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic step(input logic v, input logic [NEU-1:0] b);
    logic [NEU-1:0] nb;
    spike_valid = v;
    spike_bits  = b;
    @(posedge clk);
    m_done = 0;
    if (v) begin
      for (int n = 0; n < NEU; n++) m_cnt[n] += int'(b[n]);
      m_idx++;
      if (m_idx == WIN) begin
        for (int n = 0; n < NEU; n++) nb[n] = (m_cnt[n] >= TH);
        for (int k = DEPTH-1; k > 0; k--) m_hist[k] = m_hist[k-1];
        m_hist[0] = nb;
        for (int n = 0; n < NEU; n++) m_cnt[n] = 0;
        m_idx = 0;
        if (m_filled < DEPTH) m_filled++;
        m_done = 1;
      end
    end
    @(negedge clk);
    chk("R2 win_done", 64'(win_done), 64'(m_done));
    chk("R7 hist_full", 64'(hist_full), 64'(m_filled == DEPTH));
    for (int k = 0; k < DEPTH; k++)
      chk(m_done ? "R3/R5 slot" : "R4/R5 slot held", 64'(slot(k)), 64'(m_hist[k]));
  endtask

  function automatic logic [NEU-1:0] sparse_bits();
    logic [NEU-1:0] r;
    for (int n = 0; n < NEU; n++) r[n] = (($urandom % 16) == 0);
    return r;
  endfunction

  initial begin
    checks = 0;
    errors = 0;
    finished = 0;
    void'($urandom(32'd7741));
    do_reset();

    // R1: reset state
    chk("R1 win_done", 64'(win_done), 64'd0);
    chk("R1 hist_full", 64'(hist_full), 64'd0);
    for (int k = 0; k < DEPTH; k++) chk("R1 slot", 64'(slot(k)), 64'd0);

    // R8: one spike on neuron 5 in the first bin only
    step(1'b1, NEU'(1) << 5);
    for (int i = 1; i < WIN; i++) step(1'b1, '0);
    chk("R8 single neuron", 64'(slot(0)), 64'(NEU'(1) << 5));

    // R4: invalid cycles carrying all ones between empty valid bins
    for (int i = 0; i < WIN; i++) begin
      step(1'b0, '1);
      step(1'b1, '0);
    end
    chk("R4 invalid ignored", 64'(slot(0)), 64'd0);

    // R6: all ones in the last bin, then an empty window
    for (int i = 0; i < WIN-1; i++) step(1'b1, '0);
    step(1'b1, '1);
    chk("R6 last bin", 64'(slot(0)), 64'({NEU{1'b1}}));
    for (int i = 0; i < WIN; i++) step(1'b1, '0);
    chk("R6 cleared", 64'(slot(0)), 64'd0);
    chk("R6 previous kept", 64'(slot(1)), 64'({NEU{1'b1}}));

    // random sparse traffic, runs the history past its depth
    for (int i = 0; i < 700; i++) begin
      step(($urandom % 4) != 0, sparse_bits());
    end
    chk("R7 full after depth", 64'(hist_full), 64'd1);

    // R9: asynchronous reset clears without a clock edge
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R9 win_done", 64'(win_done), 64'd0);
    chk("R9 hist_full", 64'(hist_full), 64'd0);
    chk("R9 slot0", 64'(slot(0)), 64'd0);
    chk("R9 slot1", 64'(slot(1)), 64'd0);
    do_reset();
    for (int i = 0; i < WIN; i++) step(1'b1, sparse_bits());

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule